// File: doc/BRIEF.md
# XOR-Feedback Shift Counter with Optional Skip

This block counts by shifting. A chain of flip-flops moves its contents one place toward the last stage on every enabled clock. The first stage takes the exclusive-OR of a fixed set of tap stages. The taps depend on the chain length, which may be 3 to 12 stages. Each length steps through 2^n-1 distinct states, so the counter covers every state except all-zeros. Its next-state logic is a single XOR, whatever the length.

The all-zeros state is a dead end for XOR feedback. For this reason, both reset and the preset input load all-ones, which is also the start of each cycle. If the chain is ever found at all-zeros, a 1 is forced into the first stage. A build-time option shortens the cycle. When every stage except the first is zero, a 1 is OR-ed into the first stage, and the counter jumps over the states that would normally follow. A one-clock flag marks each return to all-ones.

Top module: `shift_seq_counter`

## Requirements
- R1: While `rst_ni` is low, `state_o` is all-ones and `wrap_o` is 0, immediately and without waiting for a clock edge.
- R2: On each rising edge with `en_i`=1 and `preset_i`=0, bit i of `state_o` takes the old bit i-1, for every i from 1 to N_STAGES-1. Bit 0 is the first stage.
- R3: On such an edge, bit 0 takes the XOR of the tap bits, unless an injection applies. The tap bits by length are: 3:{1,2} 4:{2,3} 5:{2,4} 6:{4,5} 7:{5,6} 8:{3,4,5,7} 9:{4,8} 10:{6,9} 11:{8,10} 12:{0,3,5,11}.
- R4: With 4 stages and no skip, the values of `state_o` from 4'hF are F,E,C,8,1,2,4,9,3,6,D,A,5,B,7, and the cycle then returns to F. The period is 15.
- R5: With 12 stages, the count returns to all-ones after exactly 4095 enabled steps.
- R6: An edge with `en_i`=0 and `preset_i`=0 leaves `state_o` unchanged and gives `wrap_o`=0.
- R7: `preset_i`=1 at an edge loads all-ones and gives `wrap_o`=0, whatever `en_i` is.
- R8: With SKIP_EN=1, an enabled step from a state where only bit 0 is set goes to bits 0 and 1 set. For 4 stages this gives a 12-state cycle: F,E,C,8,1,3,6,D,A,5,B,7.
- R9: `wrap_o` is 1 for exactly the one cycle after an enabled step that lands on all-ones. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Step enable |
| preset_i | input | 1 | Synchronous load of all-ones; takes priority over enable |
| state_o | output | N_STAGES | Stage vector; bit 0 is the first stage |
| wrap_o | output | 1 | One-cycle pulse on return to all-ones |

## Verification
`state_o` and `wrap_o` both come from registers. Each shows the effect of the inputs at an edge directly after that edge, with no further delay. Reset is the one exception, and it acts at once. The bench therefore changes `en_i` and `preset_i` just after a falling edge. It then waits through one rising edge and samples at the following falling edge, so every result is read one edge after its stimulus. The asynchronous reset check samples one nanosecond after `rst_ni` falls, in the middle of a cycle, before any edge can act.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
  localparam int unsigned MAX_STAGES = 12;

  // bit k set => stage k (0 = first stage) feeds the XOR
  function automatic logic [MAX_STAGES-1:0] tap_mask(input int unsigned n);
    logic [MAX_STAGES-1:0] m;
    case (n)
      3:       m = 12'b0000_0000_0110;
      4:       m = 12'b0000_0000_1100;
      5:       m = 12'b0000_0001_0100;
      6:       m = 12'b0000_0011_0000;
      7:       m = 12'b0000_0110_0000;
      8:       m = 12'b0000_1011_1000;
      9:       m = 12'b0001_0001_0000;
      10:      m = 12'b0010_0100_0000;
      11:      m = 12'b0101_0000_0000;
      12:      m = 12'b1000_0010_1001;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ssc_feedback.sv
`timescale 1ns/1ps
module ssc_feedback #(
  parameter int unsigned N_STAGES = 4,
  parameter bit          SKIP_EN  = 1'b0
) (
  input  logic [N_STAGES-1:0] state_i,
  output logic                fb_o
);
  localparam logic [ssc_pkg::MAX_STAGES-1:0] TAP_ALL = ssc_pkg::tap_mask(N_STAGES);
  localparam logic [N_STAGES-1:0] TAPS = TAP_ALL[N_STAGES-1:0];

  logic tapped;
  logic rest_zero;
  logic inject;

  assign tapped    = ^(state_i & TAPS);
  assign rest_zero = ~|state_i[N_STAGES-1:1];

  generate
    if (SKIP_EN) begin : g_skip
      // first-only state jumps; all-zeros recovers
      assign inject = rest_zero;
    end else begin : g_noskip
      // all-zeros recovery only
      assign inject = rest_zero & ~state_i[0];
    end
  endgenerate

  assign fb_o = tapped | inject;
endmodule

// File: rtl/ssc_stage_reg.sv
`timescale 1ns/1ps
module ssc_stage_reg #(
  parameter int unsigned N_STAGES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                preset_i,
  input  logic                fb_i,
  output logic [N_STAGES-1:0] state_o,
  output logic [N_STAGES-1:0] next_o
);
  logic [N_STAGES-1:0] stage_q;

  assign next_o = {stage_q[N_STAGES-2:0], fb_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stage_q <= '1;
    else if (preset_i) stage_q <= '1;
    else if (en_i)     stage_q <= next_o;
  end

  assign state_o = stage_q;
endmodule

// File: rtl/ssc_wrap_det.sv
`timescale 1ns/1ps
module ssc_wrap_det #(
  parameter int unsigned N_STAGES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic [N_STAGES-1:0] next_i,
  output logic                wrap_o
);
  logic wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wrap_q <= 1'b0;
    else         wrap_q <= step_i & (&next_i);
  end

  assign wrap_o = wrap_q;
endmodule

// File: rtl/shift_seq_counter.sv
`timescale 1ns/1ps
module shift_seq_counter #(
  parameter int unsigned N_STAGES = 4,
  parameter bit          SKIP_EN  = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                preset_i,
  output logic [N_STAGES-1:0] state_o,
  output logic                wrap_o
);
  logic                fb;
  logic                step;
  logic [N_STAGES-1:0] stage_q;
  logic [N_STAGES-1:0] shift_d;

  assign step = en_i & ~preset_i;

  ssc_feedback #(.N_STAGES(N_STAGES), .SKIP_EN(SKIP_EN)) u_fb (
    .state_i (stage_q),
    .fb_o    (fb)
  );

  ssc_stage_reg #(.N_STAGES(N_STAGES)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .preset_i (preset_i),
    .fb_i     (fb),
    .state_o  (stage_q),
    .next_o   (shift_d)
  );

  ssc_wrap_det #(.N_STAGES(N_STAGES)) u_wrap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .next_i (shift_d),
    .wrap_o (wrap_o)
  );

  assign state_o = stage_q;
endmodule

// File: rtl/shift_seq_counter_chk.sv
`timescale 1ns/1ps
module shift_seq_counter_chk #(
  parameter int unsigned N_STAGES = 4,
  parameter bit          SKIP_EN  = 1'b0
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                preset_i,
  input logic [N_STAGES-1:0] state_o,
  input logic                wrap_o
);
  localparam logic [ssc_pkg::MAX_STAGES-1:0] TAP_ALL = ssc_pkg::tap_mask(N_STAGES);
  localparam logic [N_STAGES-1:0] TAPS = TAP_ALL[N_STAGES-1:0];
  localparam logic [N_STAGES-1:0] FIRST_ONLY = N_STAGES'(1);
  localparam logic [N_STAGES-1:0] FIRST_TWO  = N_STAGES'(3);

  // R2
  shift_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !preset_i) |=> state_o[N_STAGES-1:1] == $past(state_o[N_STAGES-2:0]));

  // R3
  tap_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !preset_i && (state_o[N_STAGES-1:1] != '0))
      |=> state_o[0] == ^($past(state_o) & TAPS));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !preset_i) |=> ($stable(state_o) && !wrap_o));

  // R7
  preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> ((&state_o) && !wrap_o));

  // R9
  wrap_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (&state_o));

  // R9
  wrap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);

  generate
    if (SKIP_EN) begin : g_skip_chk
      // R8
      skip_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !preset_i && state_o == FIRST_ONLY) |=> state_o == FIRST_TWO);
    end
  endgenerate
endmodule

bind shift_seq_counter shift_seq_counter_chk #(
  .N_STAGES (N_STAGES),
  .SKIP_EN  (SKIP_EN)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .preset_i (preset_i),
  .state_o  (state_o),
  .wrap_o   (wrap_o)
);

// File: tb/shift_seq_counter_tb.sv
`timescale 1ns/1ps
module shift_seq_counter_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic preset = 1'b0;
  logic [3:0]  st4, st4s;
  logic [11:0] st12;
  logic        wr4, wr4s, wr12;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  shift_seq_counter #(.N_STAGES(4), .SKIP_EN(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .preset_i(preset), .state_o(st4), .wrap_o(wr4));
  shift_seq_counter #(.N_STAGES(4), .SKIP_EN(1'b1)) u_dut_skip (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .preset_i(preset), .state_o(st4s), .wrap_o(wr4s));
  shift_seq_counter #(.N_STAGES(12), .SKIP_EN(1'b0)) u_dut12 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .preset_i(preset), .state_o(st12), .wrap_o(wr12));

  // {wrap, state} after each step from all-ones
  localparam logic [4:0] SEQ4 [15] = '{
    5'b0_1110, 5'b0_1100, 5'b0_1000, 5'b0_0001, 5'b0_0010,
    5'b0_0100, 5'b0_1001, 5'b0_0011, 5'b0_0110, 5'b0_1101,
    5'b0_1010, 5'b0_0101, 5'b0_1011, 5'b0_0111, 5'b1_1111};
  localparam logic [4:0] SKIP4 [12] = '{
    5'b0_1110, 5'b0_1100, 5'b0_1000, 5'b0_0001, 5'b0_0011, 5'b0_0110,
    5'b0_1101, 5'b0_1010, 5'b0_0101, 5'b0_1011, 5'b0_0111, 5'b1_1111};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step(input logic e, input logic p);
    en = e;
    preset = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [11:0] prev12;
    logic [3:0]  hold4;
    int period;
    int wraps;

    repeat (2) @(negedge clk);
    check("R1 reset n4", {27'd0, wr4, st4}, 32'h0F);
    check("R1 reset skip", {27'd0, wr4s, st4s}, 32'h0F);
    check("R1 reset n12", {19'd0, wr12, st12}, 32'h0FFF);
    rst_ni = 1'b1;
    step(1'b0, 1'b0);
    check("R6 idle after reset", {27'd0, wr4, st4}, 32'h0F);

    // R4 R8 R9 table walk
    for (int k = 0; k < 24; k++) begin
      step(1'b1, 1'b0);
      check("R4/R9 seq n4", {27'd0, wr4, st4}, {27'd0, SEQ4[k % 15]});
      check("R8/R9 seq skip", {27'd0, wr4s, st4s}, {27'd0, SKIP4[k % 12]});
    end

    // R6 hold
    hold4 = st4;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0);
      check("R6 hold", {27'd0, wr4, st4}, {28'd0, hold4});
    end

    // R7 preset over enable, and with enable low
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R7 preset en=1", {27'd0, wr4, st4}, 32'h0F);
    check("R7 preset n12", {19'd0, wr12, st12}, 32'h0FFF);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    check("R7 preset en=0", {27'd0, wr4, st4}, 32'h0F);

    // R2 R3 R5 R9 on 12 stages
    period = 0;
    wraps = 0;
    for (int i = 0; i < 5000; i++) begin
      prev12 = st12;
      step(1'b1, 1'b0);
      if (st12[11:1] != prev12[10:0])
        check("R2 shift n12", {20'd0, st12}, {20'd0, prev12[10:0], st12[0]});
      if (st12[0] != (prev12[0] ^ prev12[3] ^ prev12[5] ^ prev12[11]))
        check("R3 tap n12", {31'd0, st12[0]}, {31'd0, prev12[0] ^ prev12[3] ^ prev12[5] ^ prev12[11]});
      if (wr12) wraps++;
      if (st12 == 12'hFFF) begin
        period = i + 1;
        break;
      end
    end
    check("R5 period n12", period, 4095);
    check("R9 wrap count n12", {31'd0, wr12}, 32'd1);
    check("R9 wraps seen n12", wraps, 1);
    check("R2 R3 shift/tap clean n12", fails, 0);
    step(1'b0, 1'b0);
    check("R9 wrap drops", {31'd0, wr12}, 32'd0);

    // R1 asynchronous reset mid-cycle
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R4 two steps", {28'd0, st4}, 32'hC);
    #2 rst_ni = 1'b0;
    #1;
    check("R1 async n4", {27'd0, wr4, st4}, 32'h0F);
    check("R1 async n12", {19'd0, wr12, st12}, 32'h0FFF);
    @(negedge clk);
    rst_ni = 1'b1;
    en = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule